// File: doc/BRIEF.md
# Double-Buffered Descriptor DMA Channel

This block moves words between memory and one peripheral under control of two complete transfer descriptors. Each descriptor holds a memory address, a word count and a command word. Exactly one descriptor is active at any time. It drives the memory-side request and address. Software is free to rewrite the other descriptor while the transfer runs. When the active descriptor runs out of words, it disarms itself, latches a sticky completion flag and raises the interrupt. Software then swaps the roles of the two descriptors with a swap write and continues with the prepared one.

The CPU reaches the block through a simple write-strobe register bus with combinational read data. Descriptor 0 occupies bytes 0x00..0x0B and descriptor 1 occupies bytes 0x10..0x1B. A control word at 0x20 reports and swaps the active descriptor. Memory traffic uses a request/grant pair. The block presents a word address and a write-enable that follows the transfer direction. One word moves on each cycle in which the request is granted and the peripheral is ready. Several copies can sit behind a shared register window. Arbitration between copies lies outside this block.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset, irq and mem_req are low, the control word reads 0 (descriptor 0 active), and every descriptor register reads 0.
- R2: Register map, byte addressed with word-aligned offsets: descriptor s has its address at 0x10*s+0x0, its word count at 0x10*s+0x4 (LW bits, zero-extended) and its command at 0x10*s+0x8. The control word is at 0x20. Any other address reads 0 and writes to it have no effect.
- R3: Command bits: bit 0 written 1 arms the descriptor; bit 1 is the direction; bit 2 is the sticky done flag, cleared by writing 1; bit 3 reads 1 only while the descriptor is both armed and active. Read back, bits 0..3 give armed, direction, done and busy.
- R4: While the active descriptor is armed with a nonzero count and per_rdy is high, mem_req is high and mem_addr equals the descriptor address. In each cycle with mem_gnt also high, per_ack is high, and after that edge the address has grown by 4 and the count has dropped by 1.
- R5: Direction 1 reads memory for the peripheral: mem_we is 0 and per_wdata follows mem_rdata. Direction 0 writes memory: mem_we is 1 and mem_wdata follows per_rdata.
- R6: The edge that transfers the last word disarms the descriptor and sets its done flag. irq is high from then until every done flag is cleared. Arming with a count of 0 completes one cycle later without any request.
- R7: Writes to the address, count or direction of the active descriptor are ignored while it is armed. Writes to the idle descriptor always take effect.
- R8: Writing the control word with bit 0 set swaps the active descriptor, unless the active descriptor is armed. In that case the write is ignored.
- R9: After a swap onto a descriptor that is not armed, no request is made until that descriptor is armed.
- R10: If the last-word edge and a done-clear write to the same descriptor fall in one cycle, the done flag ends up set.
- R11: While per_rdy is low, mem_req stays low and the count does not change, even with mem_gnt high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory word request |
| mem_gnt | input | 1 | Memory grant; a word moves when high with mem_req |
| mem_addr | output | AW | Memory byte address of the current word |
| mem_we | output | 1 | 1 when the word is written to memory |
| mem_wdata | output | DW | Word written to memory |
| mem_rdata | input | DW | Word read from memory |
| per_rdy | input | 1 | Peripheral ready for a word |
| per_ack | output | 1 | Word accepted this cycle |
| per_wdata | output | DW | Word delivered to the peripheral |
| per_rdata | input | DW | Word supplied by the peripheral |
| irq | output | 1 | High while any done flag is set |

## Verification
The last-word edge sets the done flag, and a software write-1 to the same command word clears it. The two can fall in the same cycle. The bench grants the final word of a one-word transfer in the same cycle that it clears done on that descriptor. It then requires the done flag to read back set and irq to stay high. A second overlap is also provoked: a swap write while the active descriptor is still armed and idle-descriptor writes during a transfer. These are judged through the control readback and the unchanged memory address.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  localparam int REG_W     = 32;
  localparam int CMD_START = 0;
  localparam int CMD_DIR   = 1;
  localparam int CMD_DONE  = 2;
  localparam int CMD_BUSY  = 3;
  localparam logic [1:0] BLK_CTRL = 2'd2;

  typedef enum logic [1:0] {
    F_ADDR = 2'd0,
    F_LEN  = 2'd1,
    F_CMD  = 2'd2,
    F_NONE = 2'd3
  } field_e;
endpackage

// File: rtl/pp_dma_desc.sv
module pp_dma_desc
  import pp_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  field_e        field,
  input  logic [AW-1:0] wr_addr_val,
  input  logic [LW-1:0] wr_len_val,
  input  logic          wr_start,
  input  logic          wr_dir,
  input  logic          wr_clr,
  input  logic          is_active,
  input  logic          step,
  input  logic          finish,
  output logic [AW-1:0] addr_o,
  output logic [LW-1:0] len_o,
  output logic          armed_o,
  output logic          dir_o,
  output logic          done_o
);
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] len_q, len_d;
  logic armed_q, armed_d, dir_q, dir_d, done_q, done_d;
  logic lock, cmd_wr;

  assign lock   = is_active & armed_q;
  assign cmd_wr = wr_en && (field == F_CMD);

  always_comb begin
    addr_d  = addr_q;
    len_d   = len_q;
    armed_d = armed_q;
    dir_d   = dir_q;
    done_d  = done_q;
    if (wr_en && field == F_ADDR && !lock) addr_d = wr_addr_val;
    else if (step)                         addr_d = addr_q + AW'(4);
    if (wr_en && field == F_LEN && !lock)  len_d = wr_len_val;
    else if (step)                         len_d = len_q - LW'(1);
    if (finish)                            armed_d = 1'b0;
    else if (cmd_wr && wr_start)           armed_d = 1'b1;
    if (cmd_wr && !lock)                   dir_d = wr_dir;
    if (finish)                            done_d = 1'b1;
    else if (cmd_wr && wr_clr)             done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      len_q   <= '0;
      armed_q <= 1'b0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      len_q   <= len_d;
      armed_q <= armed_d;
      dir_q   <= dir_d;
      done_q  <= done_d;
    end
  end

  assign addr_o  = addr_q;
  assign len_o   = len_q;
  assign armed_o = armed_q;
  assign dir_o   = dir_q;
  assign done_o  = done_q;
endmodule

// File: rtl/pp_dma_engine.sv
module pp_dma_engine #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flip_req,
  input  logic          armed_act,
  input  logic [LW-1:0] len_act,
  input  logic          per_rdy,
  input  logic          mem_gnt,
  output logic          act,
  output logic          mem_req,
  output logic          step,
  output logic          finish_act
);
  logic act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (flip_req && !armed_act) act_d = ~act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign act        = act_q;
  assign mem_req    = armed_act && (len_act != '0) && per_rdy;
  assign step       = mem_req && mem_gnt;
  assign finish_act = armed_act && ((len_act == '0) || (step && len_act == LW'(1)));
endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan
  import pp_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [5:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             mem_req,
  input  logic             mem_gnt,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_we,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             per_rdy,
  output logic             per_ack,
  output logic [DW-1:0]    per_wdata,
  input  logic [DW-1:0]    per_rdata,
  output logic             irq
);
  localparam int NSET = 2;

  logic [1:0] blk;
  field_e     fld;
  logic       aligned, flip_req, act, step, finish_act;
  logic       armed_act;
  logic [LW-1:0] len_act;
  logic [AW-1:0] set_addr [NSET];
  logic [LW-1:0] set_len  [NSET];
  logic [NSET-1:0] set_armed, set_dir, set_done;

  assign blk      = reg_addr[5:4];
  assign fld      = field_e'(reg_addr[3:2]);
  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign flip_req = reg_wr && aligned && blk == BLK_CTRL && fld == F_ADDR && reg_wdata[0];

  for (genvar s = 0; s < NSET; s++) begin : g_set
    logic sel, is_act;
    assign sel    = reg_wr && aligned && (blk == 2'(s));
    assign is_act = (act == 1'(s));
    pp_dma_desc #(.AW(AW), .LW(LW)) u_desc (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (sel),
      .field       (fld),
      .wr_addr_val (AW'(reg_wdata)),
      .wr_len_val  (LW'(reg_wdata)),
      .wr_start    (reg_wdata[CMD_START]),
      .wr_dir      (reg_wdata[CMD_DIR]),
      .wr_clr      (reg_wdata[CMD_DONE]),
      .is_active   (is_act),
      .step        (step && is_act),
      .finish      (finish_act && is_act),
      .addr_o      (set_addr[s]),
      .len_o       (set_len[s]),
      .armed_o     (set_armed[s]),
      .dir_o       (set_dir[s]),
      .done_o      (set_done[s])
    );
  end

  assign armed_act = set_armed[act];
  assign len_act   = set_len[act];

  pp_dma_engine #(.LW(LW)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .flip_req   (flip_req),
    .armed_act  (armed_act),
    .len_act    (len_act),
    .per_rdy    (per_rdy),
    .mem_gnt    (mem_gnt),
    .act        (act),
    .mem_req    (mem_req),
    .step       (step),
    .finish_act (finish_act)
  );

  assign mem_addr  = set_addr[act];
  assign mem_we    = ~set_dir[act];
  assign mem_wdata = per_rdata;
  assign per_wdata = mem_rdata;
  assign per_ack   = step;
  assign irq       = |set_done;

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      if (blk < 2'(NSET)) begin
        case (fld)
          F_ADDR:  reg_rdata = REG_W'(set_addr[blk[0]]);
          F_LEN:   reg_rdata = REG_W'(set_len[blk[0]]);
          F_CMD:   reg_rdata = REG_W'({set_armed[blk[0]] && (act == blk[0]), set_done[blk[0]],
                                       set_dir[blk[0]], set_armed[blk[0]]});
          default: reg_rdata = '0;
        endcase
      end else if (blk == BLK_CTRL && fld == F_ADDR) begin
        reg_rdata = REG_W'(act);
      end
    end
  end
endmodule

// File: rtl/pp_dma_chk.sv
module pp_dma_chk #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic [AW-1:0] mem_addr,
  input logic          act,
  input logic          armed_act,
  input logic [LW-1:0] len_act,
  input logic          irq
);
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt) |=> (mem_addr == $past(mem_addr) + AW'(4)));

  // R4
  len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt) |=> (len_act == $past(len_act) - LW'(1)));

  // R6
  last_word_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && len_act == LW'(1)) |=> irq);

  // R8
  swap_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_act |=> (act == $past(act)));

  // R9
  req_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (armed_act && len_act != '0));
endmodule

bind pp_dma_chan pp_dma_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_gnt   (mem_gnt),
  .mem_addr  (mem_addr),
  .act       (act),
  .armed_act (armed_act),
  .len_act   (len_act),
  .irq       (irq)
);

// File: tb/sim_pp_dma_chan.sv
`timescale 1ns/1ps
module sim_pp_dma_chan;
  logic        clk, rst_n, reg_wr, mem_req, mem_gnt, mem_we, per_rdy, per_ack, irq;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, mem_addr, mem_wdata, mem_rdata, per_wdata, per_rdata;
  int tests = 0, fails = 0;
  logic [31:0] rv;

  pp_dma_chan u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .per_rdy(per_rdy), .per_ack(per_ack), .per_wdata(per_wdata), .per_rdata(per_rdata),
    .irq(irq));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {address, write value, expected readback}
  localparam logic [69:0] VEC [7] = '{
    {6'h00, 32'h0000_1000, 32'h0000_1000},
    {6'h04, 32'h0000_0020, 32'h0000_0020},
    {6'h10, 32'h0000_2000, 32'h0000_2000},
    {6'h14, 32'hFFFF_0005, 32'h0000_0005},
    {6'h18, 32'h0000_0002, 32'h0000_0002},
    {6'h18, 32'h0000_0000, 32'h0000_0000},
    {6'h0C, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    tests++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    mem_gnt = 1'b0; mem_rdata = '0; per_rdy = 1'b0; per_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 mem_req", {31'b0, mem_req}, 0);
    rd(6'h20, rv); chk("R1 ctrl", rv, 0);
    rd(6'h08, rv); chk("R1 cmd0", rv, 0);
    rd(6'h14, rv); chk("R1 len1", rv, 0);

    // R2 table walk
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][69:64], VEC[i][63:32]);
      rd(VEC[i][69:64], rv);
      chk($sformatf("R2 vec%0d", i), rv, VEC[i][31:0]);
    end

    // R4/R5 transfer of 3 words from descriptor 0, memory to peripheral
    per_rdy = 1'b1;
    wr(6'h00, 32'h100); wr(6'h04, 3); wr(6'h08, 32'h3);
    #1;
    chk("R4 req", {31'b0, mem_req}, 1);
    chk("R4 addr", mem_addr, 32'h100);
    chk("R5 we dir1", {31'b0, mem_we}, 0);
    mem_rdata = 32'hCAFE_0001; #1;
    chk("R5 per_wdata", per_wdata, 32'hCAFE_0001);
    rd(6'h08, rv); chk("R3 cmd busy", rv, 32'hB);
    // R7 active armed descriptor locked, idle one writable
    wr(6'h00, 32'h999); rd(6'h00, rv); chk("R7 addr locked", rv, 32'h100);
    wr(6'h08, 32'h1);   rd(6'h08, rv); chk("R7 dir locked", rv, 32'hB);
    wr(6'h10, 32'h200); rd(6'h10, rv); chk("R7 idle write", rv, 32'h200);
    // R8 swap refused while armed
    wr(6'h20, 32'h1); rd(6'h20, rv); chk("R8 swap refused", rv, 0);
    for (int i = 0; i < 3; i++) begin
      mem_gnt = 1'b1; #1;
      chk("R4 ack", {31'b0, per_ack}, 1);
      chk("R4 addr step", mem_addr, 32'h100 + 32'(4 * i));
      @(negedge clk);
    end
    mem_gnt = 1'b0; #1;
    chk("R6 req low", {31'b0, mem_req}, 0);
    chk("R6 irq", {31'b0, irq}, 1);
    rd(6'h08, rv); chk("R6 done", rv, 32'h6);
    rd(6'h04, rv); chk("R4 len zero", rv, 0);
    wr(6'h08, 32'h4); #1;
    chk("R6 irq cleared", {31'b0, irq}, 0);

    // R8/R10 descriptor 1: one word, memory write, collision of finish and clear
    wr(6'h14, 1); wr(6'h18, 32'h1); #1;
    chk("R9 no req idle armed", {31'b0, mem_req}, 0);
    wr(6'h20, 32'h1); rd(6'h20, rv); chk("R8 swap", rv, 1);
    per_rdata = 32'h5A5A_1234; #1;
    chk("R4 req set1", {31'b0, mem_req}, 1);
    chk("R4 addr set1", mem_addr, 32'h200);
    chk("R5 we dir0", {31'b0, mem_we}, 1);
    chk("R5 mem_wdata", mem_wdata, 32'h5A5A_1234);
    mem_gnt = 1'b1; reg_wr = 1'b1; reg_addr = 6'h18; reg_wdata = 32'h4;
    @(negedge clk);
    mem_gnt = 1'b0; reg_wr = 1'b0;
    rd(6'h18, rv); chk("R10 done wins", rv, 32'h4);
    chk("R10 irq", {31'b0, irq}, 1);
    wr(6'h18, 32'h4); #1;
    chk("R6 irq clr1", {31'b0, irq}, 0);

    // R9 swap onto unarmed descriptor 0
    wr(6'h20, 32'h1); rd(6'h20, rv); chk("R9 ctrl", rv, 0);
    chk("R9 no req", {31'b0, mem_req}, 0);

    // R11 peripheral not ready
    per_rdy = 1'b0;
    wr(6'h00, 32'h300); wr(6'h04, 2); wr(6'h08, 32'h1); #1;
    chk("R11 req low", {31'b0, mem_req}, 0);
    mem_gnt = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(6'h04, rv); chk("R11 len held", rv, 2);
    mem_gnt = 1'b0; per_rdy = 1'b1; #1;
    chk("R11 req resumes", {31'b0, mem_req}, 1);
    chk("R11 addr", mem_addr, 32'h300);
    mem_gnt = 1'b1;
    @(negedge clk); @(negedge clk);
    mem_gnt = 1'b0;
    rd(6'h04, rv); chk("R4 len done", rv, 0);
    chk("R6 irq two words", {31'b0, irq}, 1);
    wr(6'h08, 32'h4);

    // R6 zero-length arm completes without request
    wr(6'h08, 32'h1); #1;
    chk("R6 zero len no req", {31'b0, mem_req}, 0);
    @(negedge clk);
    rd(6'h08, rv); chk("R6 zero len done", rv, 32'h4);
    chk("R6 zero len irq", {31'b0, irq}, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule